// File: doc/BRIEF.md
# Per-Macro Bias Code Dispatcher

This block is the digital control path that hands active-mode body-bias tap selections to several independently powered macros on one chip. It keeps a small programmable table with one 3-bit bias code per macro. Post-fabrication test fills the table by picking, for each macro, the code that lets it meet its delay target. When a macro leaves standby, the block reads that macro's code and decodes it into a one-hot tap-select word. It then routes the word through a gated demultiplexer into that macro's pair of select latches: one copy drives the NMOS-side switches and one drives the PMOS-side switches. Going into standby applies a fixed reverse bias elsewhere and never reads the table.

The demultiplexer enable stays low while the decoded word and the downstream level shifting settle. It rises only after a programmable number of settling cycles, stays high for a programmable pulse length, and then drops. Each macro's latches are loaded only while the enable is high and their macro is selected, so every other macro keeps its selection. Wake requests that arrive together are queued and served one macro at a time, lowest index first.

The table is written through a valid/ready port. `cfg_ready` is low whenever the block is busy. A writer must hold `cfg_valid` and its data until it sees `cfg_ready` high at a rising clock edge. An offer that is withdrawn before that edge has no effect.

Top module: `bbd_dispatcher`

## Requirements
- R1: After reset every select latch (both copies of every macro) reads all zeros, and `busy` and `demux_on` are low.
- R2: A dispatched code k makes the selected macro's word have only bit k set (code 0 sets bit 0, code 7 sets bit 7), and the NMOS and PMOS copies are equal.
- R3: A table write takes effect only at a rising edge where `cfg_valid` and `cfg_ready` are both high; `cfg_ready` equals the inverse of `busy`.
- R4: A write offered while `busy` is high and withdrawn before `cfg_ready` rises leaves the table unchanged, so a later wake of that macro still applies the old code.
- R5: The table is read only on a wake request; writing a code changes no latch until that macro is woken, and a wake applies the code stored for that macro.
- R6: With a wake request sampled at edge E0, `demux_on` is first high after edge E0+SETTLE_CYC+1.
- R7: Each assertion of `demux_on` lasts exactly PULSE_CYC cycles; outside these pulses it is low.
- R8: A dispatch to one macro leaves every other macro's latched words unchanged, and no latch changes while `demux_on` is low.
- R9: Macros requested in the same cycle are each served exactly once, in ascending index order; `demux_macro` names the macro being loaded while `demux_on` is high.
- R10: `busy` is high from the cycle after a wake request is sampled until the last queued dispatch has finished its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Table write offered |
| cfg_ready | output | 1 | Table write can be accepted (not busy) |
| cfg_macro | input | SEL_W | Macro index of the table entry to write |
| cfg_code | input | CODE_W | Bias code to store |
| wake_req | input | N_MACRO | One pulse per macro leaving standby |
| busy | output | 1 | Dispatch in progress or queued |
| demux_on | output | 1 | Demultiplexer enable pulse |
| demux_macro | output | SEL_W | Macro being routed to |
| tap_sel_n | output | N_MACRO*TAP_W | Latched one-hot words for NMOS switches, macro i at bits i*TAP_W upward |
| tap_sel_p | output | N_MACRO*TAP_W | Latched one-hot words for PMOS switches, same layout |

## Verification
The assertions assume that `cfg_macro` and every set bit of `wake_req` refer to an existing macro, and that SETTLE_CYC and PULSE_CYC are at least one. The pulse-length and settle-window checks also assume that the writer never relies on a write landing while `busy` is high. The stimulus draws macro indices only below N_MACRO and codes over the full 3-bit range. It issues random wake vectors only when the block is idle, except for one directed case that offers a write during a dispatch and withdraws it.

// File: rtl/bbd_pkg.sv
package bbd_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_PULSE  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bbd_code_table.sv
module bbd_code_table #(
  parameter int N      = 4,
  parameter int CODE_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [SEL_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code
);
  logic [N-1:0][CODE_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en && (int'(wr_idx) < N)) begin
      mem[wr_idx] <= wr_code;
    end
  end

  always_comb begin
    rd_code = '0;
    if (int'(rd_idx) < N) rd_code = mem[rd_idx];
  end

  AST_TABLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(mem)); // R4
endmodule

// File: rtl/bbd_arbiter.sv
module bbd_arbiter #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             take,
  output logic             any,
  output logic [SEL_W-1:0] idx
);
  logic [N-1:0] pend;
  logic [N-1:0] clr;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = SEL_W'(i);
    end
  end

  always_comb begin
    clr = '0;
    if (take) clr[idx] = 1'b1;
  end

  assign any = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | req;
  end

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend[idx]); // R9
endmodule

// File: rtl/bbd_sequencer.sv
module bbd_sequencer
  import bbd_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int SEL_W  = 2,
  parameter int SETTLE = 3,
  parameter int PULSE  = 2,
  localparam int TAP_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_any,
  input  logic [SEL_W-1:0]  pend_idx,
  input  logic [CODE_W-1:0] code_in,
  output logic              take,
  output logic              active,
  output logic              en,
  output logic [SEL_W-1:0]  sel,
  output logic [TAP_W-1:0]  word
);
  localparam int CNT_MAX = (SETTLE > PULSE) ? SETTLE : PULSE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int AGE_W   = CNT_W + 1;

  seq_state_t         state;
  logic [CNT_W-1:0]   cnt;
  logic [TAP_W-1:0]   word_d;

  for (genvar b = 0; b < TAP_W; b++) begin : g_dec
    assign word_d[b] = (code_in == CODE_W'(b));
  end

  assign take   = (state == SQ_IDLE) && pend_any;
  assign active = (state != SQ_IDLE);
  assign en     = (state == SQ_PULSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
      sel   <= '0;
      word  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (pend_any) begin
            state <= SQ_SETTLE;
            cnt   <= '0;
            sel   <= pend_idx;
            word  <= word_d;
          end
        end
        SQ_SETTLE: begin
          if (cnt == CNT_W'(SETTLE - 1)) begin
            state <= SQ_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_PULSE: begin
          if (cnt == CNT_W'(PULSE - 1)) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // checker counters: cycles since grant, cycles of enable high
  logic [AGE_W-1:0] chk_age;
  logic [AGE_W-1:0] chk_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_age <= '1;
      chk_len <= '0;
    end else begin
      if (take)          chk_age <= '0;
      else if (~&chk_age) chk_age <= chk_age + 1'b1;
      if (en) chk_len <= chk_len + 1'b1;
      else    chk_len <= '0;
    end
  end

  AST_EN_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (chk_age == AGE_W'(SETTLE))); // R6
  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (chk_len == AGE_W'(PULSE))); // R7
  AST_WORD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> $onehot(word)); // R2
endmodule

// File: rtl/bbd_latch_bank.sv
module bbd_latch_bank #(
  parameter int N     = 4,
  parameter int TAP_W = 8,
  parameter int SEL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  input  logic [TAP_W-1:0]   word,
  output logic [N*TAP_W-1:0] tap_n,
  output logic [N*TAP_W-1:0] tap_p
);
  for (genvar i = 0; i < N; i++) begin : g_mac
    logic [TAP_W-1:0] lat_n;
    logic [TAP_W-1:0] lat_p;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat_n <= '0;
        lat_p <= '0;
      end else if (en && (sel == SEL_W'(i))) begin
        lat_n <= word;
        lat_p <= word;
      end
    end
    assign tap_n[i*TAP_W +: TAP_W] = lat_n;
    assign tap_p[i*TAP_W +: TAP_W] = lat_p;

    AST_LATCH_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lat_n)); // R2
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(tap_n) && $stable(tap_p))); // R8
endmodule

// File: rtl/bbd_dispatcher.sv
module bbd_dispatcher #(
  parameter int N_MACRO    = 4,
  parameter int CODE_W     = 3,
  parameter int SETTLE_CYC = 3,
  parameter int PULSE_CYC  = 2,
  localparam int SEL_W     = (N_MACRO > 1) ? $clog2(N_MACRO) : 1,
  localparam int TAP_W     = 1 << CODE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_valid,
  output logic                     cfg_ready,
  input  logic [SEL_W-1:0]         cfg_macro,
  input  logic [CODE_W-1:0]        cfg_code,
  input  logic [N_MACRO-1:0]       wake_req,
  output logic                     busy,
  output logic                     demux_on,
  output logic [SEL_W-1:0]         demux_macro,
  output logic [N_MACRO*TAP_W-1:0] tap_sel_n,
  output logic [N_MACRO*TAP_W-1:0] tap_sel_p
);
  logic              pend_any;
  logic [SEL_W-1:0]  pend_idx;
  logic              take;
  logic              active;
  logic [CODE_W-1:0] rd_code;
  logic [TAP_W-1:0]  word;

  assign busy      = active | pend_any;
  assign cfg_ready = ~busy;

  bbd_code_table #(.N(N_MACRO), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (busy),
    .wr_en   (cfg_valid & cfg_ready),
    .wr_idx  (cfg_macro),
    .wr_code (cfg_code),
    .rd_idx  (pend_idx),
    .rd_code (rd_code)
  );

  bbd_arbiter #(.N(N_MACRO), .SEL_W(SEL_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (wake_req),
    .take  (take),
    .any   (pend_any),
    .idx   (pend_idx)
  );

  bbd_sequencer #(.CODE_W(CODE_W), .SEL_W(SEL_W), .SETTLE(SETTLE_CYC),
                  .PULSE(PULSE_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_any (pend_any),
    .pend_idx (pend_idx),
    .code_in  (rd_code),
    .take     (take),
    .active   (active),
    .en       (demux_on),
    .sel      (demux_macro),
    .word     (word)
  );

  bbd_latch_bank #(.N(N_MACRO), .TAP_W(TAP_W), .SEL_W(SEL_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (demux_on),
    .sel   (demux_macro),
    .word  (word),
    .tap_n (tap_sel_n),
    .tap_p (tap_sel_p)
  );

  AST_BUSY_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_req) |=> busy); // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cfg_ready); // R3
endmodule

// File: tb/bbd_dispatcher_test.sv
module bbd_dispatcher_test;
  localparam int N  = 4;
  localparam int CW = 3;
  localparam int TW = 8;
  localparam int SW = 2;
  localparam int S  = 3;
  localparam int P  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [SW-1:0] cfg_macro = '0;
  logic [CW-1:0] cfg_code = '0;
  logic [N-1:0]  wake_req = '0;
  logic          busy;
  logic          demux_on;
  logic [SW-1:0] demux_macro;
  logic [N*TW-1:0] tap_sel_n;
  logic [N*TW-1:0] tap_sel_p;

  bbd_dispatcher #(.N_MACRO(N), .CODE_W(CW), .SETTLE_CYC(S), .PULSE_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_macro(cfg_macro), .cfg_code(cfg_code), .wake_req(wake_req),
    .busy(busy), .demux_on(demux_on), .demux_macro(demux_macro),
    .tap_sel_n(tap_sel_n), .tap_sel_p(tap_sel_p));

  int n_chk = 0;
  int n_fail = 0;
  int tbl[N];
  int exp_tap[N];
  int log_sel[16];
  int log_n = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int word_of(input int code);
    return 1 << code;
  endfunction

  // monitor: log macro at each enable rise, measure pulse length (R7, R9)
  logic en_d = 1'b0;
  int run = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      en_d = 1'b0;
      run = 0;
    end else begin
      if (demux_on && !en_d) begin
        if (log_n < 16) log_sel[log_n] = int'(demux_macro);
        log_n++;
      end
      if (demux_on) run++;
      else if (en_d) begin
        check(run == P, "R7 pulse length", run, P);
        run = 0;
      end
      en_d = demux_on;
    end
  end

  task automatic compare_all(input string tag);
    for (int i = 0; i < N; i++) begin
      check(int'(tap_sel_n[i*TW +: TW]) == exp_tap[i], tag, int'(tap_sel_n[i*TW +: TW]), exp_tap[i]);
      check(int'(tap_sel_p[i*TW +: TW]) == exp_tap[i], tag, int'(tap_sel_p[i*TW +: TW]), exp_tap[i]);
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (!busy) return;
    end
    check(1'b0, "R10 busy never cleared", 1, 0);
  endtask

  task automatic write_code(input int idx, input int code);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_macro = SW'(idx);
    cfg_code  = CW'(code);
    for (int k = 0; k < 500 && !cfg_ready; k++) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
    tbl[idx] = code;
  endtask

  task automatic wake(input logic [N-1:0] vec);
    @(negedge clk);
    wake_req = vec;
    @(negedge clk);
    wake_req = '0;
    for (int i = 0; i < N; i++) if (vec[i]) exp_tap[i] = word_of(tbl[i]);
  endtask

  task automatic wake_and_check_order(input logic [N-1:0] vec, input string tag);
    int pos;
    log_n = 0;
    wake(vec);
    wait_idle();
    check(log_n == $countones(vec), tag, log_n, $countones(vec));
    pos = 0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        if (pos < log_n && pos < 16)
          check(log_sel[pos] == i, tag, log_sel[pos], i);
        pos++;
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < N; i++) begin
      tbl[i] = 0;
      exp_tap[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    compare_all("R1 reset latches");
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(demux_on == 1'b0, "R1 demux_on after reset", int'(demux_on), 0);
    check(cfg_ready == 1'b1, "R3 ready when idle", int'(cfg_ready), 1);

    // R5 writes alone do not move latches
    write_code(0, 5);
    write_code(1, 0);
    write_code(2, 7);
    write_code(3, 2);
    compare_all("R5 write without wake");

    // R6 enable delay, R10 busy
    @(negedge clk);
    wake_req = 4'b0001;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        wake_req = '0;
        check(busy == 1'b1, "R10 busy after wake", int'(busy), 1);
        check(cfg_ready == 1'b0, "R3 ready low while busy", int'(cfg_ready), 0);
      end
    end while (!demux_on && k < 50);
    check(k == S + 2, "R6 enable delay", k, S + 2);
    check(demux_macro == 0, "R9 demux_macro", int'(demux_macro), 0);
    exp_tap[0] = word_of(tbl[0]);
    wait_idle();
    compare_all("R2 R8 single wake");

    // R2 boundary codes 0 and 7
    wake_and_check_order(4'b0110, "R9 order 1,2");
    compare_all("R2 codes 0 and 7");

    // R9 simultaneous requests
    write_code(0, 3);
    write_code(3, 6);
    wake_and_check_order(4'b1011, "R9 order 0,1,3");
    compare_all("R8 others held after multi wake");

    // R4 write offered while busy then withdrawn
    @(negedge clk);
    wake_req = 4'b0100;
    @(negedge clk);
    wake_req = '0;
    cfg_valid = 1'b1;
    cfg_macro = 2'd2;
    cfg_code  = 3'd1;
    check(cfg_ready == 1'b0, "R3 ready low during dispatch", int'(cfg_ready), 0);
    @(negedge clk);
    cfg_valid = 1'b0;
    exp_tap[2] = word_of(tbl[2]);
    wait_idle();
    compare_all("R4 dispatch during offered write");
    wake_and_check_order(4'b0100, "R9 single 2");
    compare_all("R4 table kept old code");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int r;
      r = int'($urandom % 3);
      if (r == 0) begin
        write_code(int'($urandom % N), int'($urandom % 8));
        compare_all("R5 random write");
      end else begin
        logic [N-1:0] v;
        v = N'($urandom);
        if (v == '0) v = 4'b1000;
        wake_and_check_order(v, "R9 random order");
        compare_all("R2 R8 random wake");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule